// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the bytes of one page write for a 256-page, 32-byte-per-page storage array and then commits them in a single timed write window. A start strobe carries a 13-bit byte address. The block keeps the page part of that address for the whole transfer and uses the low part as a moving byte offset. Each load strobe puts one data byte into a page-wide staging buffer at the current offset and sets that slot's valid flag. The offset then advances and wraps around inside the same page, so a later byte can overwrite an earlier one.

A commit request raises a busy flag for a programmable number of clock cycles. On the last busy cycle the staged bytes are merged into an on-chip RAM that stands in for non-volatile cells. Only slots whose valid flag is set replace the stored bytes. While busy is high, the block refuses new starts, loads and commits. When the window ends, the valid flags are cleared. The array reads back as all FFh after reset. The write port is also driven on the outputs, and a combinational read port lets the rest of the chip see the contents.

Top module: `page_write_buffer`

## Requirements
- R1: A byte address splits into a page number (bits 12..5) and a byte offset (bits 4..0). A byte loaded right after a start at address A is stored at A, and reading address A on the read port returns it.
- R2: The page number is captured by the start strobe. Every byte loaded afterwards goes into that page, and nothing is ever stored in a neighbouring page.
- R3: Each accepted load advances the offset by one. Offset 31 is followed by offset 0 of the same page, and a byte loaded into an already-loaded slot replaces the earlier byte.
- R4: A commit changes only the byte slots that were loaded since the last start. Every other byte of the page keeps its previous value.
- R5: The array is updated once, on the last cycle of the busy window. During the window the read port still returns the old contents, and once busy is low it returns the new ones.
- R6: Busy goes high on the cycle after an accepted commit request and stays high for exactly WR_CYCLES clock cycles.
- R7: After reset, busy is low and every array byte reads FFh.
- R8: A commit request that arrives when no slot is loaded is dropped, and busy stays low.
- R9: Start, load and commit strobes are ignored while busy is high. The valid flags are cleared when the window ends, so a later commit with no new loads does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_valid | input | 1 | Start strobe: begins a transfer at st_addr |
| st_addr | input | 13 | Start byte address (page in 12..5, offset in 4..0) |
| ld_valid | input | 1 | Load strobe for one data byte |
| ld_data | input | 8 | Byte to stage |
| cmt_req | input | 1 | Request to commit the staged bytes |
| busy | output | 1 | High during the timed write window |
| arr_we | output | 1 | Array write pulse (last busy cycle) |
| arr_page | output | 8 | Page being written |
| arr_wbe | output | 32 | Per-byte write enables |
| arr_wdata | output | 256 | Staged page data, byte k in bits 8k+7..8k |
| rd_addr | input | 13 | Read byte address |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |

## Verification
The bench loads 34 bytes starting two slots before the end of a page. A design whose offset carried into the page number would change the next page, and one that did not wrap would lose the two overwriting bytes. A partial rewrite of a page already holding data exposes a design that writes unloaded slots back as FFh or as stale buffer contents. A read taken during the busy window catches an update that lands too early, and counting the busy cycles catches an off-by-one in the timer. Strobes sent during the window, followed by a commit with nothing loaded, expose a design that accepts loads while busy or forgets to clear its valid flags.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic {TMR_IDLE, TMR_RUN} tmr_state_e;

  // Next slot index inside a page of 'slots' entries, wrapping to zero.
  function automatic int unsigned slot_after(input int unsigned cur, input int unsigned slots);
    return (cur + 1 >= slots) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/pgbuf_collect.sv
module pgbuf_collect
  import pgbuf_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_W     = 13,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W,
  localparam int DATA_W    = PAGE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic                  ld_valid,
  input  logic [7:0]            ld_data,
  input  logic                  cmt_req,
  input  logic                  busy,
  input  logic                  done,
  output logic [PAGE_W-1:0]     page_o,
  output logic [PAGE_BYTES-1:0] vld_o,
  output logic [DATA_W-1:0]     data_o,
  output logic                  cmt_go
);

  logic [PAGE_W-1:0]     page_q;
  logic [OFF_W-1:0]      ptr_q;
  logic [OFF_W-1:0]      ptr_nx;
  logic [PAGE_BYTES-1:0] vld_q;
  logic                  st_take;
  logic                  ld_take;

  // Start wins over a load in the same cycle; both are refused while busy.
  assign st_take = st_valid & ~busy;
  assign ld_take = ld_valid & ~busy & ~st_valid;
  assign cmt_go  = cmt_req & ~busy & (|vld_q);
  assign ptr_nx  = OFF_W'(slot_after(int'(ptr_q), PAGE_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ptr_q  <= '0;
      vld_q  <= '0;
    end else if (st_take) begin
      page_q <= st_addr[ADDR_W-1:OFF_W];
      ptr_q  <= st_addr[OFF_W-1:0];
      vld_q  <= '0;
    end else if (ld_take) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= ptr_nx;
    end else if (done) begin
      vld_q <= '0;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (ld_take && ptr_q == OFF_W'(g)) slot_q <= ld_data;
    end
    assign data_o[g*8 +: 8] = slot_q;
  end

  assign page_o = page_q;
  assign vld_o  = vld_q;

  assert_load_marks_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_take |=> vld_q[$past(ptr_q)]);

  assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(vld_q) && $stable(page_q) && $stable(ptr_q)));

  assert_clear_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (vld_q == '0));

endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer
  import pgbuf_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 500000,
  localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic done
);

  tmr_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TMR_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        TMR_IDLE: if (go) begin
          st_q  <= TMR_RUN;
          cnt_q <= CNT_W'(WR_CYCLES - 1);
        end
        TMR_RUN: begin
          if (cnt_q == '0) st_q <= TMR_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= TMR_IDLE;
      endcase
    end
  end

  assign busy = (st_q == TMR_RUN);
  assign done = busy && (cnt_q == '0);

  assert_go_raises_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(cnt_q) < WR_CYCLES));

  assert_done_ends_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> !busy);

endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array #(
  parameter int PAGE_COUNT = 256,
  parameter int PAGE_BYTES = 32,
  localparam int PAGE_W    = $clog2(PAGE_COUNT),
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int DATA_W    = PAGE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [PAGE_W-1:0]     wpage,
  input  logic [PAGE_BYTES-1:0] wbe,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [PAGE_W-1:0]     rd_page,
  input  logic [OFF_W-1:0]      rd_off,
  output logic [7:0]            rd_data
);

  // One row per page; a per-page flag stands for the erased (all FFh) state.
  logic [DATA_W-1:0]     mem [PAGE_COUNT];
  logic [PAGE_COUNT-1:0] written_q;
  logic [DATA_W-1:0]     old_word;
  logic [DATA_W-1:0]     new_word;
  logic [DATA_W-1:0]     rd_word;
  logic [7:0]            rd_bytes [PAGE_BYTES];

  assign old_word = written_q[wpage]   ? mem[wpage]   : '1;
  assign rd_word  = written_q[rd_page] ? mem[rd_page] : '1;

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_byte
    assign new_word[b*8 +: 8] = wbe[b] ? wdata[b*8 +: 8] : old_word[b*8 +: 8];
    assign rd_bytes[b]        = rd_word[b*8 +: 8];
  end

  assign rd_data = rd_bytes[rd_off];

  always_ff @(posedge clk) begin
    if (we) mem[wpage] <= new_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  written_q        <= '0;
    else if (we) written_q[wpage] <= 1'b1;
  end

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int          PAGE_COUNT = 256,
  parameter int          PAGE_BYTES = 32,
  parameter int unsigned WR_CYCLES  = 500000,
  localparam int PAGE_W = $clog2(PAGE_COUNT),
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int ADDR_W = PAGE_W + OFF_W,
  localparam int DATA_W = PAGE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic                  ld_valid,
  input  logic [7:0]            ld_data,
  input  logic                  cmt_req,
  output logic                  busy,
  output logic                  arr_we,
  output logic [PAGE_W-1:0]     arr_page,
  output logic [PAGE_BYTES-1:0] arr_wbe,
  output logic [DATA_W-1:0]     arr_wdata,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data
);

  logic cmt_go;
  logic wr_done;

  pgbuf_collect #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_addr  (st_addr),
    .ld_valid (ld_valid),
    .ld_data  (ld_data),
    .cmt_req  (cmt_req),
    .busy     (busy),
    .done     (wr_done),
    .page_o   (arr_page),
    .vld_o    (arr_wbe),
    .data_o   (arr_wdata),
    .cmt_go   (cmt_go)
  );

  pgbuf_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (cmt_go),
    .busy  (busy),
    .done  (wr_done)
  );

  assign arr_we = wr_done;

  pgbuf_array #(.PAGE_COUNT(PAGE_COUNT), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (arr_we),
    .wpage   (arr_page),
    .wbe     (arr_wbe),
    .wdata   (arr_wdata),
    .rd_page (rd_addr[ADDR_W-1:OFF_W]),
    .rd_off  (rd_addr[OFF_W-1:0]),
    .rd_data (rd_data)
  );

  assert_empty_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_req && !busy && arr_wbe == '0) |=> !busy);

  assert_write_has_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_wbe != '0));

  assert_write_ends_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !busy);

endmodule

// File: tb/test_page_write_buffer.sv
module test_page_write_buffer;

  localparam int WR = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         st_valid = 1'b0;
  logic [12:0]  st_addr = '0;
  logic         ld_valid = 1'b0;
  logic [7:0]   ld_data = '0;
  logic         cmt_req = 1'b0;
  logic         busy;
  logic         arr_we;
  logic [7:0]   arr_page;
  logic [31:0]  arr_wbe;
  logic [255:0] arr_wdata;
  logic [12:0]  rd_addr = '0;
  logic [7:0]   rd_data;

  always #4 clk = ~clk;

  page_write_buffer #(.WR_CYCLES(WR)) i_page_write_buffer (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .ld_valid(ld_valid), .ld_data(ld_data), .cmt_req(cmt_req), .busy(busy),
    .arr_we(arr_we), .arr_page(arr_page), .arr_wbe(arr_wbe), .arr_wdata(arr_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_err = 0;

  // Bench model of the array and the staging buffer.
  logic [7:0] model [int];
  int         b_page;
  int         b_ptr;
  logic [7:0] b_dat [32];
  bit         b_vld [32];

  function automatic logic [7:0] mval(input int a);
    return model.exists(a) ? model[a] : 8'hFF;
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = 13'(a);
    #1;
    v = rd_data;
  endtask

  task automatic chk_mem(input string req, input int a);
    logic [7:0] v;
    rd(a, v);
    chk8(req, v, mval(a));
  endtask

  task automatic op_start(input int a, input bit upd);
    @(negedge clk);
    st_valid = 1'b1;
    st_addr  = 13'(a);
    @(posedge clk);
    #1 st_valid = 1'b0;
    if (upd) begin
      b_page = a / 32;
      b_ptr  = a % 32;
      for (int i = 0; i < 32; i++) b_vld[i] = 1'b0;
    end
  endtask

  task automatic op_load(input logic [7:0] d, input bit upd);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_data  = d;
    @(posedge clk);
    #1 ld_valid = 1'b0;
    if (upd) begin
      b_dat[b_ptr] = d;
      b_vld[b_ptr] = 1'b1;
      b_ptr        = (b_ptr + 1) % 32;
    end
  endtask

  task automatic apply_model();
    for (int i = 0; i < 32; i++) begin
      if (b_vld[i]) model[b_page * 32 + i] = b_dat[i];
      b_vld[i] = 1'b0;
    end
  endtask

  task automatic pulse_commit();
    @(negedge clk);
    cmt_req = 1'b1;
    @(posedge clk);
    #1 cmt_req = 1'b0;
  endtask

  // Commit, count busy cycles, probe one address during and after the window.
  task automatic commit_timed(input int probe);
    logic [7:0] old_v;
    logic [7:0] v;
    int cnt;
    old_v = mval(probe);
    pulse_commit();
    chk1("R6 busy after commit", busy, 1'b1);
    cnt = 1;
    rd(probe, v);
    chk8("R5 old data during window", v, old_v);
    while (cnt < 1000) begin
      @(posedge clk);
      #1;
      if (busy) cnt++;
      else break;
    end
    chk_int("R6 busy length", cnt, WR);
    apply_model();
    chk_mem("R5 new data after window", probe);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk1("R7 busy low after reset", busy, 1'b0);
    chk_mem("R7 erased at 0x0000", 0);
    chk_mem("R7 erased at 0x1FFF", 13'h1FFF);
    chk_mem("R7 erased at 0x1234", 13'h1234);
  endtask

  task automatic t_byte_write();
    op_start(13'h1234, 1'b1);
    op_load(8'hA5, 1'b1);
    commit_timed(13'h1234);
    chk8("R1 byte at start address", mval(13'h1234), 8'hA5);
    chk_mem("R1 read port at 0x1234", 13'h1234);
    chk_mem("R4 untouched 0x1233", 13'h1233);
    chk_mem("R4 untouched 0x1235", 13'h1235);
  endtask

  task automatic t_wrap();
    int base;
    base = 200 * 32;
    op_start(base + 30, 1'b1);
    for (int k = 0; k < 34; k++) op_load(8'(8'h40 + k), 1'b1);
    commit_timed(base + 30);
    chk8("R3 offset 30 overwritten", mval(base + 30), 8'h60);
    chk_mem("R3 offset 30", base + 30);
    chk_mem("R3 offset 31", base + 31);
    chk_mem("R3 offset 0 after wrap", base + 0);
    chk_mem("R3 offset 1", base + 1);
    chk_mem("R3 offset 15", base + 15);
    chk_mem("R2 next page untouched", base + 32);
    chk_mem("R2 previous page untouched", base - 1);
  endtask

  task automatic t_partial();
    int base;
    base = 5 * 32;
    op_start(base + 10, 1'b1);
    op_load(8'h11, 1'b1);
    op_load(8'h22, 1'b1);
    op_load(8'h33, 1'b1);
    commit_timed(base + 10);
    op_start(base + 11, 1'b1);
    op_load(8'h77, 1'b1);
    commit_timed(base + 11);
    chk_mem("R4 kept offset 10", base + 10);
    chk_mem("R4 replaced offset 11", base + 11);
    chk_mem("R4 kept offset 12", base + 12);
    chk_mem("R4 erased offset 9", base + 9);
  endtask

  task automatic t_empty_commit();
    op_start(13'h0100, 1'b1);
    pulse_commit();
    chk1("R8 no busy on empty commit", busy, 1'b0);
    repeat (3) @(posedge clk);
    #1 chk1("R8 still idle", busy, 1'b0);
    chk_mem("R8 array unchanged", 13'h0100);
  endtask

  task automatic t_busy_ignore();
    op_start(13'h0400, 1'b1);
    op_load(8'h99, 1'b1);
    pulse_commit();
    chk1("R9 window open", busy, 1'b1);
    op_start(13'h0800, 1'b0);
    op_load(8'h5A, 1'b0);
    pulse_commit();
    for (int i = 0; i < 1000 && busy; i++) begin
      @(posedge clk);
      #1;
    end
    apply_model();
    pulse_commit();
    chk1("R9 no busy after cleared flags", busy, 1'b0);
    for (int i = 0; i < 1000 && busy; i++) begin
      @(posedge clk);
      #1;
    end
    chk_mem("R9 accepted byte", 13'h0400);
    chk_mem("R9 ignored load not at 0x0401", 13'h0401);
    chk_mem("R9 ignored start not at 0x0800", 13'h0800);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_byte_write();
    t_wrap();
    t_partial();
    t_empty_commit();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule